// File: doc/BRIEF.md
# Pipelined Multiplier Modulo 2^64 - 2^32 + 1

This block multiplies two 64-bit residues and returns their product reduced modulo the prime P = 2^64 - 2^32 + 1 = 0xFFFFFFFF00000001. Both operands must already lie in [0, P). A qualifying valid flag travels with each operand pair, and the result leaves the block with its own valid flag a fixed number of cycles later. The block accepts a new pair on every clock cycle.

The full 128-bit product comes from a pipelined 64x64 integer multiplier built from four 32x32 partial products. Because of the special form of P, the upper product words fold back into the lower word with shifts, additions and subtractions only. The identities used are 2^64 = 2^32 - 1 and 2^96 = -1 (mod P). Two registered folding stages follow the multiplier. The total latency is the multiplier depth plus two, which is 8 cycles by default.

The block is intended as the arithmetic core of a number-theoretic-transform butterfly or an element-wise multiply stage. Its user supplies reduced operands and consumes one result per cycle.

Top module: `pmod_mul64`

## Requirements
- R1: For operands a and b in [0, P), with P = 0xFFFFFFFF00000001, `result` equals (a*b) mod P whenever `out_valid` is high.
- R2: Whenever `out_valid` is high, `result` is strictly less than P.
- R3: `out_valid` is high in a cycle exactly when `in_valid` was high MUL_STAGES+2 cycles earlier (8 by default), assuming no reset intervened.
- R4: Pairs presented on consecutive cycles are all accepted, and their results emerge on consecutive cycles in the same order.
- R5: While `rst` is high, and for MUL_STAGES+2 cycles after it, no result is flagged valid. Pairs already in flight when `rst` rises are discarded.
- R6: A cycle with `in_valid` low yields a cycle with `out_valid` low MUL_STAGES+2 cycles later, whatever the operand values in that cycle.
- R7: Operand values 0, 1 and P-1 give exact results. In particular, (P-1)*(P-1) gives 1, x*0 gives 0 and x*1 gives x.
- R8: Products whose bits 127:96 exceed their bits 63:0 are reduced correctly. For these products the first fold step borrows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair qualifier |
| op_a | input | 64 | First operand, in [0, P) |
| op_b | input | 64 | Second operand, in [0, P) |
| out_valid | output | 1 | Result qualifier |
| result | output | 64 | (op_a*op_b) mod P |

## Verification
Two events can land on the same clock edge: a synchronous reset, and the emission of results that are already inside the pipeline. The bench provokes this by asserting reset in the middle of an unbroken stream of valid pairs. It then expects the in-flight results to vanish at the output and expects the stream to resume exactly eight cycles after reset is released, with correct values. Values are judged against a 128-bit product followed by a modulo in the bench. The stimulus is an all-pairs sweep of boundary operands, a stream with bubbles, and random pairs. The bench also counts products that exercise the borrow path.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
  localparam int unsigned RES_W  = 64;
  localparam int unsigned HALF_W = RES_W / 2;
  localparam int unsigned PROD_W = 2 * RES_W;
  // Modulus 2^64 - 2^32 + 1
  localparam logic [RES_W-1:0] PRIME = 64'hFFFF_FFFF_0000_0001;
  // 2^64 mod PRIME, i.e. 2^32 - 1
  localparam logic [RES_W-1:0] WRAP  = 64'h0000_0000_FFFF_FFFF;
  typedef logic [RES_W-1:0]  res_t;
  typedef logic [PROD_W-1:0] prod_t;
endpackage

// File: rtl/pmod_mult_pipe.sv
module pmod_mult_pipe
  import pmod_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_v,
  input  res_t  a,
  input  res_t  b,
  output logic  out_v,
  output prod_t prod
);
  // stage 1: operand capture, stage 2: partial products, stage 3: sum,
  // remaining stages: delay to the configured depth
  localparam int unsigned TAIL = MUL_STAGES - 2;
  localparam int unsigned PP_W = 2 * HALF_W;

  res_t             a_q, b_q;
  logic [PP_W-1:0]  pp_q [4];
  prod_t            dly_q [TAIL];
  logic [MUL_STAGES-1:0] v_q;

  always_ff @(posedge clk) begin
    a_q <= a;
    b_q <= b;
  end

  for (genvar gi = 0; gi < 4; gi++) begin : g_pp
    localparam int unsigned SA = (gi / 2) * HALF_W;
    localparam int unsigned SB = (gi % 2) * HALF_W;
    always_ff @(posedge clk) begin
      pp_q[gi] <= PP_W'(a_q[SA +: HALF_W]) * PP_W'(b_q[SB +: HALF_W]);
    end
  end

  prod_t pp_sum;
  always_comb begin
    pp_sum = PROD_W'(pp_q[0])
           + (PROD_W'(pp_q[1]) << HALF_W)
           + (PROD_W'(pp_q[2]) << HALF_W)
           + (PROD_W'(pp_q[3]) << RES_W);
  end

  always_ff @(posedge clk) begin
    dly_q[0] <= pp_sum;
    for (int k = 1; k < int'(TAIL); k++) begin
      dly_q[k] <= dly_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[MUL_STAGES-2:0], in_v};
  end

  assign prod  = dly_q[TAIL-1];
  assign out_v = v_q[MUL_STAGES-1];
endmodule

// File: rtl/pmod_reduce.sv
module pmod_reduce
  import pmod_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_v,
  input  prod_t prod,
  output logic  out_v,
  output res_t  res
);
  // fold stage: lo - top (borrow repaired), mid * (2^32 - 1)
  logic [HALF_W-1:0] w_mid, w_top;
  res_t              w_lo;
  logic [RES_W:0]    diff;
  res_t              t_d, m_d, t_q, m_q;
  logic              v_a;

  always_comb begin
    w_lo  = prod[RES_W-1:0];
    w_mid = prod[RES_W +: HALF_W];
    w_top = prod[RES_W+HALF_W +: HALF_W];
    diff  = {1'b0, w_lo} - {{(RES_W-HALF_W+1){1'b0}}, w_top};
    // a borrow means the wrapped value is 2^64 too big; adding PRIME
    // equals subtracting 2^64 - PRIME = WRAP
    t_d   = diff[RES_W] ? (diff[RES_W-1:0] - WRAP) : diff[RES_W-1:0];
    m_d   = {w_mid, {HALF_W{1'b0}}} - {{HALF_W{1'b0}}, w_mid};
  end

  always_ff @(posedge clk) begin
    t_q <= t_d;
    m_q <= m_d;
  end

  // sum stage: carry folds back as WRAP, then one conditional subtract
  logic [RES_W:0] sum;
  res_t           u, r_d;
  logic           v_b;

  always_comb begin
    sum = {1'b0, t_q} + {1'b0, m_q};
    u   = sum[RES_W] ? (sum[RES_W-1:0] + WRAP) : sum[RES_W-1:0];
    r_d = (u >= PRIME) ? (u - PRIME) : u;
  end

  always_ff @(posedge clk) begin
    res <= r_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_a <= 1'b0;
      v_b <= 1'b0;
    end else begin
      v_a <= in_v;
      v_b <= v_a;
    end
  end

  assign out_v = v_b;
endmodule

// File: rtl/pmod_mul64.sv
module pmod_mul64
  import pmod_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int unsigned LATENCY = MUL_STAGES + 2;

  logic  mv;
  prod_t mp;

  pmod_mult_pipe #(.MUL_STAGES(MUL_STAGES)) u_mult (
    .clk   (clk),
    .rst   (rst),
    .in_v  (in_valid),
    .a     (op_a),
    .b     (op_b),
    .out_v (mv),
    .prod  (mp)
  );

  pmod_reduce u_red (
    .clk   (clk),
    .rst   (rst),
    .in_v  (mv),
    .prod  (mp),
    .out_v (out_valid),
    .res   (result)
  );
endmodule

// File: rtl/pmod_mul64_chk.sv
module pmod_mul64_chk
  import pmod_pkg::*;
#(
  parameter int unsigned LAT = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        out_valid,
  input logic [63:0] result
);
  logic [LAT-1:0] vsr;
  res_t           ref_q [LAT];
  prod_t          full;

  assign full = PROD_W'(op_a) * PROD_W'(op_b);

  always_ff @(posedge clk) begin
    if (rst) vsr <= '0;
    else     vsr <= {vsr[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    ref_q[0] <= RES_W'(full % PROD_W'(PRIME));
    for (int k = 1; k < int'(LAT); k++) ref_q[k] <= ref_q[k-1];
  end

  assert_value_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result == ref_q[LAT-1]));

  assert_below_prime_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result < PRIME));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsr[LAT-1]);

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind pmod_mul64 pmod_mul64_chk #(.LAT(LATENCY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/tb_pmod_mul64.sv
module tb_pmod_mul64;
  import pmod_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  int slot   = 0;
  int borrow_hits = 0;
  bit done = 1'b0;

  logic        vh [16];
  logic [63:0] dh [16];
  string       th [16];
  string       vt [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmod_mul64 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] edge_val(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h2;
      3: return WRAP;
      4: return 64'h0000_0001_0000_0000;
      5: return 64'h0000_0001_0000_0001;
      6: return 64'h8000_0000_0000_0000;
      7: return PRIME - 64'd2;
      8: return PRIME - 64'd1;
      9: return 64'hFFFF_FFFE_FFFF_FFFF;
      10: return 64'h8000_0000_FFFF_FFFF;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  function automatic bit is_corner(input logic [63:0] x);
    return (x == 64'h0) || (x == 64'h1) || (x == PRIME - 64'd1);
  endfunction

  // one cycle: check what left the pipe, then drive the next stimulus
  task automatic step(input bit rs, input bit v, input logic [63:0] a,
                      input logic [63:0] b, input string tag);
    logic [127:0] pr;
    int idx;
    int cur;
    @(negedge clk);
    if (slot >= LAT) begin
      idx = (slot - LAT) % 16;
      chk(out_valid == vh[idx], vt[idx], 64'(out_valid), 64'(vh[idx]));
      if (vh[idx] && out_valid) begin
        chk(result == dh[idx], th[idx], result, dh[idx]);
        chk(result < PRIME, "R2", result, PRIME);
      end
    end else begin
      chk(out_valid == 1'b0, "R5", 64'(out_valid), 64'h0);
    end
    rst = rs; in_valid = v; op_a = a; op_b = b;
    cur = slot % 16;
    pr = 128'(a) * 128'(b);
    dh[cur] = 64'(pr % 128'(PRIME));
    vh[cur] = v && !rs;
    vt[cur] = rs ? "R5" : (v ? "R3" : "R6");
    if (pr[127:96] > 128'(pr[63:0])) begin
      th[cur] = "R8";
      if (v && !rs) borrow_hits++;
    end else if (is_corner(a) || is_corner(b)) th[cur] = "R7";
    else th[cur] = tag;
    if (rs) begin
      for (int k = 1; k < LAT; k++) begin
        if (slot - k >= 0) begin
          vh[(slot - k) % 16] = 1'b0;
          vt[(slot - k) % 16] = "R5";
        end
      end
    end
    slot++;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      vh[i] = 1'b0; dh[i] = '0; th[i] = "R1"; vt[i] = "R5";
    end
    // valid pairs offered during reset must never emerge (R5)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 64'd3 + 64'(i), 64'd5, "R5");
    // back-to-back sweep over all pairs of boundary values (R4, R7)
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        step(1'b0, 1'b1, edge_val(i), edge_val(j), "R4");
    // bubbles carry garbage operands that must not surface (R6)
    for (int i = 0; i < 200; i++)
      step(1'b0, (i % 3) != 0, {$urandom, $urandom} % PRIME,
           {$urandom, $urandom} % PRIME, "R1");
    // random stream with a reset in mid-flight (R1, R5)
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500 || i == 1501)
        step(1'b1, 1'b1, 64'hDEAD_BEEF, 64'hCAFE, "R5");
      else
        step(1'b0, 1'b1, {$urandom, $urandom} % PRIME,
             {$urandom, $urandom} % PRIME, "R1");
    end
    // high-word operands force the borrow path (R8)
    for (int i = 0; i < 50; i++)
      step(1'b0, 1'b1, 64'h8000_0000_0000_0000 | 64'($urandom),
           64'hC000_0000_0000_0000 | 64'($urandom), "R8");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, '0, "R6");
    chk(borrow_hits > 0, "R8", 64'(borrow_hits), 64'h1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", slot, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule